// File: doc/BRIEF.md
# Trace Word Unpacker

This block takes 32-bit words read out of a trace capture store and turns each one into a stream of trace samples. Every sample carries a 3-bit pipeline status, a packet field, a sync flag and a trigger flag. Words arrive over a valid/ready handshake, and samples leave over a second valid/ready handshake at a rate of at most one per clock.

A 2-bit mode input tells the block how many samples a word holds and where their fields sit. With a 4-bit trace port a word holds three samples. With an 8-bit port it holds two. With a 16-bit port it holds one. The mode is captured together with the word, so the upstream side may change it freely between words.

A sample whose status field equals the trigger code is reported with its real status taken from the low three bits of its packet, and with the trigger flag raised. Samples leave in order of increasing bit position inside a word, and words are handled in the order they arrive.

Top module: `trc_unpack`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Mode 2'b00 (4-bit port): each word yields three samples, based at word bits 0, 8 and 16. Relative to its base, a sample has status in bits 2:0, packet in bits 6:3 and sync in bit 7.
- R3: Mode 2'b01 (8-bit port): each word yields two samples, based at word bits 0 and 12. Relative to its base, a sample has status in bits 2:0, packet in bits 10:3 and sync in bit 11.
- R4: Mode 2'b10 (16-bit port), and also the spare code 2'b11: each word yields one sample with status in bits 2:0, packet in bits 18:3 and sync in bit 19.
- R5: out_packet is 16 bits wide. In the narrower modes its upper bits are zero.
- R6: If the extracted status equals TRIG_CODE (default 3'b110), out_status shows packet bits 2:0 and out_trig is 1. Otherwise out_status shows the extracted status and out_trig is 0.
- R7: Samples of one word leave in order of increasing base bit. Words are emitted in the order they were accepted.
- R8: in_ready is high exactly when no sample is pending, or when the last pending sample is taken in that same cycle (out_valid and out_ready both high). out_valid is high exactly when a sample is pending.
- R9: While out_valid is high and out_ready is low, all sample outputs hold their values.
- R10: The mode is sampled only when a word is accepted. Changing in_mode while a word is being unpacked does not alter that word's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A stored word is offered |
| in_ready | output | 1 | The block accepts the offered word this cycle |
| in_word | input | 32 | Stored trace word |
| in_mode | input | 2 | Port-width mode: 00 4-bit, 01 8-bit, 10/11 16-bit |
| out_valid | output | 1 | A sample is presented |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_status | output | 3 | Pipeline status of the sample, after trigger substitution |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag of the sample |
| out_trig | output | 1 | Sample carried the trigger status code |

## Verification
The bench targets the handover between words. In that cycle the last sample of one word is taken while the next word is accepted. A design that refused the word there would lose throughput, and one that accepted it early would drop or overwrite a sample. It also flips in_mode on every cycle while a word is being unpacked. A design that read the live mode instead of the captured one would fetch fields from the wrong offsets. Words are seeded with the trigger code at every sample base in every mode, which exposes a status that is not substituted or a trigger flag that sticks. Random backpressure exposes outputs that drift while a sample is stalled.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
// Shared widths, mode encoding and sample record for the trace word unpacker.
package trc_pkg;
    parameter int WORD_W = 32;
    parameter int STAT_W = 3;
    parameter int PKT_W  = 16;
    parameter int IDX_W  = 2;

    typedef enum logic [1:0] {
        MODE_P4   = 2'b00,
        MODE_P8   = 2'b01,
        MODE_P16  = 2'b10,
        MODE_P16X = 2'b11
    } trc_mode_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [PKT_W-1:0]  packet;
        logic              sync;
        logic              trig;
    } trc_sample_t;

    // Number of samples a stored word carries in the given mode.
    function automatic logic [IDX_W-1:0] slots_of(trc_mode_e m);
        case (m)
            MODE_P4: return 2'd3;
            MODE_P8: return 2'd2;
            default: return 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/trc_word_hold.sv
`timescale 1ns/1ps
// Holds the word being unpacked, its captured mode and the slot index.
// Assumes: downstream takes a sample on out_valid & out_ready; a new word
// is accepted only once the last sample is gone or leaves this cycle.
module trc_word_hold
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  trc_mode_e         in_mode,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output logic [WORD_W-1:0] word_q,
    output trc_mode_e         mode_q,
    output logic [IDX_W-1:0]  idx_q
);
    logic last;
    logic accept;

    // Last slot of the held word is being presented.
    assign last     = (idx_q == slots_of(mode_q) - 2'd1);
    assign in_ready = !full || (take && last);
    assign accept   = in_valid && in_ready;

    // Load a new word or step through the slots of the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            word_q <= '0;
            mode_q <= MODE_P16;
            idx_q  <= '0;
        end else if (accept) begin
            full   <= 1'b1;
            word_q <= in_word;
            mode_q <= in_mode;
            idx_q  <= '0;
        end else if (take) begin
            if (last) begin
                full <= 1'b0;
            end else begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end
endmodule

// File: rtl/trc_slot_extract.sv
`timescale 1ns/1ps
// Pulls the raw fields of one sample out of the held word.
// Assumes: idx is below the slot count for the mode; trig is left clear here.
module trc_slot_extract
    import trc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  trc_mode_e         mode,
    input  logic [IDX_W-1:0]  idx,
    output trc_sample_t       raw
);
    localparam int P4_SLOTS  = 3;
    localparam int P4_STRIDE = 8;
    localparam int P4_PW     = 4;
    localparam int P8_SLOTS  = 2;
    localparam int P8_STRIDE = 12;
    localparam int P8_PW     = 8;
    localparam int P16_PW    = PKT_W;

    trc_sample_t p4_s [P4_SLOTS];
    trc_sample_t p8_s [P8_SLOTS];
    trc_sample_t p16_s;

    genvar g;
    generate
        for (g = 0; g < P4_SLOTS; g++) begin : g_p4
            assign p4_s[g].status = word[g*P4_STRIDE +: STAT_W];
            assign p4_s[g].packet = {{(PKT_W-P4_PW){1'b0}}, word[g*P4_STRIDE+STAT_W +: P4_PW]};
            assign p4_s[g].sync   = word[g*P4_STRIDE+STAT_W+P4_PW];
            assign p4_s[g].trig   = 1'b0;
        end
        for (g = 0; g < P8_SLOTS; g++) begin : g_p8
            assign p8_s[g].status = word[g*P8_STRIDE +: STAT_W];
            assign p8_s[g].packet = {{(PKT_W-P8_PW){1'b0}}, word[g*P8_STRIDE+STAT_W +: P8_PW]};
            assign p8_s[g].sync   = word[g*P8_STRIDE+STAT_W+P8_PW];
            assign p8_s[g].trig   = 1'b0;
        end
    endgenerate

    assign p16_s.status = word[STAT_W-1:0];
    assign p16_s.packet = word[STAT_W +: P16_PW];
    assign p16_s.sync   = word[STAT_W+P16_PW];
    assign p16_s.trig   = 1'b0;

    // Select the lane for the captured mode and the current slot.
    always_comb begin
        case (mode)
            MODE_P4: begin
                if (idx == 2'd2)      raw = p4_s[2];
                else if (idx == 2'd1) raw = p4_s[1];
                else                  raw = p4_s[0];
            end
            MODE_P8: raw = idx[0] ? p8_s[1] : p8_s[0];
            default: raw = p16_s;
        endcase
    end
endmodule

// File: rtl/trc_trig_fix.sv
`timescale 1ns/1ps
// Replaces a trigger-coded status with the packet's low bits and flags it.
// Assumes: the incoming sample has trig clear.
module trc_trig_fix
    import trc_pkg::*;
#(
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  trc_sample_t raw,
    output trc_sample_t fixed
);
    // Substitute status and raise the flag on the trigger code.
    always_comb begin
        fixed = raw;
        if (raw.status == TRIG_CODE) begin
            fixed.status = raw.packet[STAT_W-1:0];
            fixed.trig   = 1'b1;
        end
    end
endmodule

// File: rtl/trc_unpack.sv
`timescale 1ns/1ps
// Trace word unpacker top: one stored word in, one to three samples out.
// Assumes: both sides follow valid/ready; in_mode is valid with in_word.
module trc_unpack
    import trc_pkg::*;
#(
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_word,
    input  logic [1:0]  in_mode,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [2:0]  out_status,
    output logic [15:0] out_packet,
    output logic        out_sync,
    output logic        out_trig
);
    logic              full;
    logic [WORD_W-1:0] word_q;
    trc_mode_e         mode_q;
    logic [IDX_W-1:0]  idx_q;
    trc_sample_t       raw;
    trc_sample_t       fixed;
    logic              take;

    assign take = full && out_ready;

    trc_word_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_mode  (trc_mode_e'(in_mode)),
        .take     (take),
        .in_ready (in_ready),
        .full     (full),
        .word_q   (word_q),
        .mode_q   (mode_q),
        .idx_q    (idx_q)
    );

    trc_slot_extract u_ext (
        .word (word_q),
        .mode (mode_q),
        .idx  (idx_q),
        .raw  (raw)
    );

    trc_trig_fix #(.TRIG_CODE(TRIG_CODE)) u_fix (
        .raw   (raw),
        .fixed (fixed)
    );

    assign out_valid  = full;
    assign out_status = fixed.status;
    assign out_packet = fixed.packet;
    assign out_sync   = fixed.sync;
    assign out_trig   = fixed.trig;
endmodule

// File: rtl/trc_unpack_chk.sv
`timescale 1ns/1ps
// Protocol and field checks for trc_unpack, attached by bind.
module trc_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [2:0]  out_status,
    input logic [15:0] out_packet,
    input logic        out_sync,
    input logic        out_trig,
    input logic [1:0]  cur_mode
);
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8

    AST_MORE_SLOTS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_ready) |=> out_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_packet) && $stable(out_status)
                                       && $stable(out_sync) && $stable(out_trig))); // R9

    AST_TRIG_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_trig) |-> (out_status == out_packet[2:0])); // R6

    AST_P4_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cur_mode == 2'b00) |-> (out_packet[15:4] == 12'd0)); // R5

    AST_P8_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cur_mode == 2'b01) |-> (out_packet[15:8] == 8'd0)); // R5
endmodule

bind trc_unpack trc_unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_status (out_status),
    .out_packet (out_packet),
    .out_sync   (out_sync),
    .out_trig   (out_trig),
    .cur_mode   (mode_q)
);

// File: tb/trc_unpack_test.sv
`timescale 1ns/1ps
// Bench for trc_unpack: behavioural sample queue compared every cycle.
module trc_unpack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_status;
    logic [15:0] out_packet;
    logic        out_sync;
    logic        out_trig;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [2:0]  st;
        logic [15:0] pk;
        logic        sy;
        logic        tg;
    } smp_t;

    smp_t  q[$];
    string qtag[$];
    int    qpw[$];

    bit          prev_stall = 1'b0;
    logic [20:0] prev_out;

    always #2 clk = ~clk;

    trc_unpack uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_mode(in_mode), .out_valid(out_valid),
        .out_ready(out_ready), .out_status(out_status), .out_packet(out_packet),
        .out_sync(out_sync), .out_trig(out_trig)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model of one word: append its samples to the expected queue.
    task automatic push_word(input logic [31:0] w, input logic [1:0] m, input string tag);
        int n      = (m == 2'b00) ? 3 : (m == 2'b01) ? 2 : 1;
        int stride = (m == 2'b00) ? 8 : (m == 2'b01) ? 12 : 0;
        int pw     = (m == 2'b00) ? 4 : (m == 2'b01) ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            logic [31:0] sh = w >> (k * stride);
            smp_t s;
            s.st = sh[2:0];
            s.pk = 16'((sh >> 3) & ((32'd1 << pw) - 1));
            s.sy = sh[3 + pw];
            s.tg = 1'b0;
            if (s.st == 3'b110) begin
                s.st = s.pk[2:0];
                s.tg = 1'b1;
            end
            q.push_back(s);
            qtag.push_back(s.tg ? {tag, " R6 R7"} : {tag, " R7"});
            qpw.push_back(pw);
        end
    endtask

    // Put the trigger code at every sample base of every mode.
    function automatic logic [31:0] seed_trig(input logic [31:0] w);
        logic [31:0] r = w;
        r[2:0]   = 3'b110;
        r[10:8]  = 3'b110;
        r[14:12] = 3'b110;
        r[18:16] = 3'b110;
        return r;
    endfunction

    // One cycle: drive, check against the model, then advance the model.
    task automatic step(input int vpct, input int rpct, input int mode_sel,
                        input bit trig, input bit flip);
        bit exp_ready;
        string tag;
        @(negedge clk);
        in_valid  = ($urandom % 100) < vpct;
        out_ready = ($urandom % 100) < rpct;
        in_word   = trig ? seed_trig($urandom) : $urandom;
        in_mode   = flip ? 2'($urandom % 4) : 2'(mode_sel);
        #1;
        exp_ready = (q.size() == 0) || (q.size() == 1 && out_ready);
        chk(out_valid == (q.size() != 0), "R8", "out_valid", out_valid, q.size() != 0);
        chk(in_ready == exp_ready, "R8", "in_ready", in_ready, exp_ready);
        if (q.size() != 0 && out_valid) begin
            smp_t e = q[0];
            chk({out_status, out_packet, out_sync, out_trig} == e, qtag[0], "sample",
                {out_status, out_packet, out_sync, out_trig}, e);
            chk((32'(out_packet) >> qpw[0]) == 0, "R5", "packet upper bits",
                out_packet, 32'(e.pk));
        end
        if (prev_stall)
            chk({out_status, out_packet, out_sync, out_trig} == prev_out, "R9", "stalled sample",
                {out_status, out_packet, out_sync, out_trig}, prev_out);
        prev_stall = out_valid && !out_ready;
        prev_out   = {out_status, out_packet, out_sync, out_trig};
        if (q.size() != 0 && out_ready) begin
            void'(q.pop_front());
            void'(qtag.pop_front());
            void'(qpw.pop_front());
        end
        if (in_valid && exp_ready) begin
            tag = flip ? "R10" : (in_mode == 2'b00) ? "R2" : (in_mode == 2'b01) ? "R3" : "R4";
            push_word(in_word, in_mode, tag);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        for (int m = 0; m < 4; m++) begin
            repeat (40)  step(100, 100, m, 1'b0, 1'b0);
            repeat (150) step(70, 50, m, 1'b0, 1'b0);
            repeat (100) step(80, 60, m, 1'b1, 1'b0);
        end
        repeat (400) step(90, 35, 0, 1'b0, 1'b1);
        repeat (300) step(90, 50, 0, 1'b1, 1'b1);
        repeat (200) step(100, 100, 0, 1'b0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule